// File: doc/BRIEF.md
# Parking Bus Arbiter

This block arbitrates one shared bus among up to eight masters. Each master drives a request line. The arbiter returns a registered one-hot grant and the encoded number of the owning master. A new owner is chosen only at an arbitration point, meaning a cycle in which the bus is not busy or a phase timeout has just fired. While a transfer is in progress, the grant holds. Among several requesters, the lowest-numbered one wins.

When no master is requesting, a two-bit mode in the configuration word decides where the grant rests. It can rest on nobody, on the master that last won a real request, or on a master chosen in the same word. A master that already holds a parked grant can start its transfer at once, with no arbitration cycle.

Two watchdogs, one for the address phase and one for the data phase, can be enabled in the configuration word. Each counts the cycles its phase stays outstanding. When the limit is reached, the watchdog pulses an error output for one cycle and forces an arbitration point.

Software reaches the configuration word through a plain write strobe with write data, and a continuously driven read value. A write takes effect at the next arbitration point.

Top module: `bus_park_arbiter`

## Requirements
- R1: After reset, the grant is all zeros, the owner ID is 0, the error output is 0 and the configuration word reads 0x8000_0006.
- R2: At an arbitration point with one or more requests, the grant goes one cycle later to the lowest-numbered requester.
- R3: While `bus_busy` is high and no timeout fires, the grant and the owner ID do not change, whatever the requests do.
- R4: With mode bits 6:5 at 00 or 01, the grant becomes all zeros at an arbitration point with no requests.
- R5: With mode bits 6:5 at 10, an idle grant rests on the last master granted for a real request. Before any such grant, it rests on master 0.
- R6: With mode bits 6:5 at 11, an idle grant rests on master n, where n is the value of bits 10:8.
- R7: The configuration word stores bit 31, bits 10:8, bits 6:5, bit 2 and bit 1. All other bits read as zero and ignore writes.
- R8: With bit 1 set, if `addr_pend` stays high for 255 consecutive cycles, `to_err` pulses high for exactly one cycle and the grant is re-arbitrated in that same cycle.
- R9: With bit 2 set, `data_pend` held high for 255 consecutive cycles causes the same one-cycle pulse on `to_err`.
- R10: With a phase's enable bit cleared, that phase never raises `to_err`, however long it stays outstanding.
- R11: A configuration write made while the bus is busy does not change parking until the bus is no longer busy.
- R12: Whenever the grant is non-zero, its single set bit is at the position given by `gnt_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 8 | Request line of each master |
| bus_busy | input | 1 | A transfer is in progress on the bus |
| addr_pend | input | 1 | Address phase outstanding |
| data_pend | input | 1 | Data phase outstanding |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read value |
| gnt | output | 8 | One-hot grant |
| gnt_id | output | 3 | Number of the granted master |
| to_err | output | 1 | One-cycle timeout error pulse |

## Verification
The bench builds the block with its default parameters: eight masters and a 255-cycle timeout. Eight masters let the tests park on master 7 through the select field and check priority across the whole request vector. The full 255-cycle window keeps the exact cycle on which each watchdog fires within reach of a short run. Each watchdog is checked on that exact cycle, and it is also held well past the window with its enable cleared.

// File: rtl/arb_pkg.sv
// Package: shared types for the parking bus arbiter.
// Assumes a 32-bit configuration word with fixed field positions.
package arb_pkg;

    localparam int CFG_W = 32;
    localparam int SEL_W = 3;

    // Parking mode encoding (bits 6:5 of the configuration word)
    typedef enum logic [1:0] {
        PARK_NONE = 2'b00,
        PARK_RSVD = 2'b01,
        PARK_LAST = 2'b10,
        PARK_PROG = 2'b11
    } park_mode_e;

    typedef struct packed {
        logic             pipe_off;   // bit 31, stored only
        logic [SEL_W-1:0] park_sel;   // bits 10:8
        park_mode_e       park_mode;  // bits 6:5
        logic             dat_to_en;  // bit 2
        logic             adr_to_en;  // bit 1
    } arb_cfg_t;

    localparam arb_cfg_t CFG_RESET = '{
        pipe_off:  1'b1,
        park_sel:  '0,
        park_mode: PARK_NONE,
        dat_to_en: 1'b1,
        adr_to_en: 1'b1
    };

endpackage

// File: rtl/arb_cfg_reg.sv
// Module: arb_cfg_reg
// Holds the configuration word. A written copy is kept for readback, and an
// active copy, used by the rest of the block, loads from it only at
// arbitration points. Assumes a single write strobe with no address.
module arb_cfg_reg
    import arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             arb_pt,
    output logic [CFG_W-1:0] rdata,
    output arb_cfg_t         act
);

    arb_cfg_t shadow_q;

    // Capture software writes into the readback copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= CFG_RESET;
        end else if (we) begin
            shadow_q.pipe_off  <= wdata[31];
            shadow_q.park_sel  <= wdata[10:8];
            shadow_q.park_mode <= park_mode_e'(wdata[6:5]);
            shadow_q.dat_to_en <= wdata[2];
            shadow_q.adr_to_en <= wdata[1];
        end
    end

    // Move the written copy into use only between transfers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act <= CFG_RESET;
        end else if (arb_pt) begin
            act <= shadow_q;
        end
    end

    // Assemble the read value; reserved positions are zero
    always_comb begin
        rdata        = '0;
        rdata[31]    = shadow_q.pipe_off;
        rdata[10:8]  = shadow_q.park_sel;
        rdata[6:5]   = shadow_q.park_mode;
        rdata[2]     = shadow_q.dat_to_en;
        rdata[1]     = shadow_q.adr_to_en;
    end

    AST_CFG_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_pt |=> $stable(act)); // R11

endmodule

// File: rtl/arb_phase_timer.sv
// Module: arb_phase_timer
// Counts consecutive cycles of an outstanding bus phase while enabled.
// On the LIMIT-th cycle it raises fire for that cycle and restarts.
// Assumes pend stays high for as long as the phase is outstanding.
module arb_phase_timer #(
    parameter int LIMIT = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pend,
    output logic fire
);

    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             run;

    assign run  = en && pend;
    assign fire = run && (cnt_q == CNT_W'(LIMIT - 1));

    // Advance while the phase is outstanding; clear when it ends or fires
    always_ff @(posedge clk) begin
        if (!rst_n || !run || fire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(LIMIT)); // R8

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/arb_core.sv
// Module: arb_core
// Fixed-priority grant register with idle parking. It updates only when
// arb_pt is high. Assumes at most eight masters (3-bit park select).
module arb_core
    import arb_pkg::*;
#(
    parameter int N_MASTERS = 8,
    localparam int ID_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req,
    input  logic                 arb_pt,
    input  park_mode_e           mode,
    input  logic [SEL_W-1:0]     park_sel,
    output logic [N_MASTERS-1:0] gnt,
    output logic [ID_W-1:0]      gnt_id
);

    logic            win_any;
    logic [ID_W-1:0] win_id;
    logic            park_on;
    logic [ID_W-1:0] park_id;
    logic [ID_W-1:0] last_q;

    // Find the lowest-numbered requester
    always_comb begin
        win_any = 1'b0;
        win_id  = '0;
        for (int i = N_MASTERS - 1; i >= 0; i--) begin
            if (req[i]) begin
                win_any = 1'b1;
                win_id  = ID_W'(i);
            end
        end
    end

    // Choose the idle resting place from the parking mode
    always_comb begin
        unique case (mode)
            PARK_LAST: begin park_on = 1'b1; park_id = last_q;              end
            PARK_PROG: begin park_on = 1'b1; park_id = park_sel[ID_W-1:0];  end
            default:   begin park_on = 1'b0; park_id = '0;                  end
        endcase
    end

    // Register the grant and remember the last real winner
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt    <= '0;
            gnt_id <= '0;
            last_q <= '0;
        end else if (arb_pt) begin
            if (win_any) begin
                gnt    <= N_MASTERS'(1) << win_id;
                gnt_id <= win_id;
                last_q <= win_id;
            end else if (park_on) begin
                gnt    <= N_MASTERS'(1) << park_id;
                gnt_id <= park_id;
            end else begin
                gnt    <= '0;
                gnt_id <= '0;
            end
        end
    end

    AST_GNT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R2

    AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_pt |=> $stable(gnt) && $stable(gnt_id)); // R3

    AST_NOPARK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_pt && !(|req) && !mode[1]) |=> (gnt == '0)); // R4

    AST_ID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0) |-> gnt[gnt_id]); // R12

endmodule

// File: rtl/bus_park_arbiter.sv
// Module: bus_park_arbiter
// Top level: configuration word, two phase watchdogs and the grant core.
// An arbitration point is any cycle with the bus free or a watchdog firing.
// Assumes bus_busy is driven by the current owner for a whole transfer.
module bus_park_arbiter
    import arb_pkg::*;
#(
    parameter int N_MASTERS = 8,
    parameter int TO_LIMIT  = 255,
    localparam int ID_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req,
    input  logic                 bus_busy,
    input  logic                 addr_pend,
    input  logic                 data_pend,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [CFG_W-1:0]     cfg_rdata,
    output logic [N_MASTERS-1:0] gnt,
    output logic [ID_W-1:0]      gnt_id,
    output logic                 to_err
);

    arb_cfg_t   act_cfg;
    logic [1:0] phase_pend;
    logic [1:0] phase_en;
    logic [1:0] phase_fire;
    logic       arb_pt;

    assign phase_pend = {data_pend, addr_pend};
    assign phase_en   = {act_cfg.dat_to_en, act_cfg.adr_to_en};
    assign arb_pt     = !bus_busy || (|phase_fire);

    arb_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .arb_pt(arb_pt),
        .rdata (cfg_rdata),
        .act   (act_cfg)
    );

    // One watchdog per bus phase: index 0 address, index 1 data
    for (genvar p = 0; p < 2; p++) begin : g_phase
        arb_phase_timer #(.LIMIT(TO_LIMIT)) u_tmr (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (phase_en[p]),
            .pend (phase_pend[p]),
            .fire (phase_fire[p])
        );
    end

    arb_core #(.N_MASTERS(N_MASTERS)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .arb_pt  (arb_pt),
        .mode    (act_cfg.park_mode),
        .park_sel(act_cfg.park_sel),
        .gnt     (gnt),
        .gnt_id  (gnt_id)
    );

    // Register a one-cycle error pulse for any watchdog expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_err <= 1'b0;
        end else begin
            to_err <= |phase_fire;
        end
    end

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        to_err |=> !to_err); // R8

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_err) |-> $past(addr_pend || data_pend)); // R9

endmodule

// File: tb/tb_bus_park_arbiter.sv
module tb_bus_park_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  req = '0;
    logic        bus_busy = 1'b0;
    logic        addr_pend = 1'b0;
    logic        data_pend = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [7:0]  gnt;
    logic [2:0]  gnt_id;
    logic        to_err;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    bus_park_arbiter dut (
        .clk(clk), .rst_n(rst_n), .req(req), .bus_busy(bus_busy),
        .addr_pend(addr_pend), .data_pend(data_pend), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .gnt(gnt),
        .gnt_id(gnt_id), .to_err(to_err)
    );

    // Advance n edges; inputs and samples sit 1 ns after the edge
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic check_gnt(input string tag, input logic [7:0] exp);
        check(gnt == exp, tag, 32'(gnt), 32'(exp));
        if (exp != 0)
            check(32'(gnt_id) == 32'($clog2(exp)), {tag, " R12 id"}, 32'(gnt_id), 32'($clog2(exp)));
    endtask

    task automatic write_cfg(input logic [31:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        check_gnt("R1 grant", 8'h00);
        check(gnt_id == 0, "R1 id", 32'(gnt_id), 0);
        check(to_err == 0, "R1 err", 32'(to_err), 0);
        check(cfg_rdata == 32'h8000_0006, "R1 cfg", cfg_rdata, 32'h8000_0006);
    endtask

    task automatic t_regs;
        write_cfg(32'hFFFF_FFFF);
        check(cfg_rdata == 32'h8000_0766, "R7 ones", cfg_rdata, 32'h8000_0766);
        write_cfg(32'h0000_0000);
        check(cfg_rdata == 32'h0, "R7 zeros", cfg_rdata, 0);
        write_cfg(32'h8000_0006);
        tick(3);
    endtask

    task automatic t_priority;
        req = 8'b1010_1000;
        tick(1);
        check_gnt("R2 low of 3,5,7", 8'h08);
        req = 8'b1000_0000;
        tick(1);
        check_gnt("R2 single 7", 8'h80);
        req = 8'hFF;
        tick(1);
        check_gnt("R2 all", 8'h01);
        req = 8'h00;
        tick(1);
        check_gnt("R4 mode00 idle", 8'h00);
    endtask

    task automatic t_park_last;
        write_cfg(32'h0000_0046);   // mode 10
        tick(2);
        check_gnt("R5 park last", 8'h01);
        req = 8'h20;
        tick(1);
        check_gnt("R5 grant 5", 8'h20);
        req = 8'h00;
        tick(2);
        check_gnt("R5 park on 5", 8'h20);
        write_cfg(32'h0000_0026);   // mode 01 reserved
        tick(2);
        check_gnt("R4 mode01 idle", 8'h00);
    endtask

    task automatic t_park_prog;
        write_cfg(32'h0000_0766);   // mode 11, select 7
        tick(2);
        check_gnt("R6 park 7", 8'h80);
        write_cfg(32'h0000_0666);   // select 6
        tick(2);
        check_gnt("R6 park 6", 8'h40);
    endtask

    task automatic t_busy_defer;
        req = 8'h40; bus_busy = 1'b1;
        tick(1);
        check_gnt("R3 owner 6", 8'h40);
        write_cfg(32'h0000_0006);   // mode 00 while busy
        req = 8'h02;
        tick(4);
        check_gnt("R3 hold busy", 8'h40);
        req = 8'h00;
        tick(2);
        check_gnt("R11 deferred", 8'h40);
        bus_busy = 1'b0;
        tick(3);
        check_gnt("R11 applied", 8'h00);
    endtask

    task automatic t_timeout(input bit data_ph);
        int n;
        bit seen;
        req = 8'h08;
        tick(1);
        check_gnt(data_ph ? "R9 owner 3" : "R8 owner 3", 8'h08);
        bus_busy = 1'b1; req = 8'h0A;
        if (data_ph) data_pend = 1'b1; else addr_pend = 1'b1;
        n = 0; seen = 0;
        while (!seen && n < 400) begin
            tick(1);
            n++;
            if (to_err) seen = 1;
        end
        check(n == 255, data_ph ? "R9 fire cycle" : "R8 fire cycle", 32'(n), 255);
        if (!data_ph) check_gnt("R8 rearbitrate", 8'h02);
        tick(1);
        check(to_err == 0, data_ph ? "R9 pulse" : "R8 pulse", 32'(to_err), 0);
        addr_pend = 1'b0; data_pend = 1'b0; bus_busy = 1'b0; req = 8'h00;
        tick(2);
    endtask

    task automatic t_disabled;
        bit seen;
        write_cfg(32'h0000_0000);
        tick(2);
        bus_busy = 1'b1; addr_pend = 1'b1; data_pend = 1'b1;
        seen = 0;
        for (int i = 0; i < 600; i++) begin
            tick(1);
            if (to_err) seen = 1;
        end
        check(!seen, "R10 no error", 32'(seen), 0);
        bus_busy = 1'b0; addr_pend = 1'b0; data_pend = 1'b0;
        tick(1);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_priority();
        t_park_last();
        t_park_prog();
        t_busy_defer();
        t_timeout(1'b0);
        t_timeout(1'b1);
        t_disabled();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule